// File: doc/BRIEF.md
# Gated 13/16-Bit Timer-Counter

A single timer-counter channel of the kind found next to a small processor core. It counts ticks from one of three sources: the system clock itself, a free-running divide-by-12 time base, or falling edges on an external count pin. The external pin is brought into the clock domain through a two-flop synchronizer.

The count is held in two software-visible bytes, a low byte and a high byte. In 16-bit mode the two bytes join into one counter. In 13-bit mode only the low five bits of the low byte count, and they carry into the high byte. An overflow flag is set when the active count wraps from all ones to zero. Software clears the flag with a strobe.

Counting is allowed only while the run bit is set. When the gate-enable bit is set, counting also needs the external gate input to be high. Software can use this to measure the width of a high pulse on that input.

Top module: `gate_timer`

## Requirements
- R1: A synchronous reset clears both count bytes, the overflow flag, the prescaler and the synchronizer.
- R2: The count advances on a source tick only when `run_en`=1 and either `gate_en`=0 or `gate_in`=1.
- R3: With `gate_en`=0 the level of `gate_in` has no effect. With `run_en`=0 the count holds whatever `gate_en` and `gate_in` are.
- R4: Setting `run_en` does not change the count. Counting resumes from the value last written or accumulated.
- R5: With `mode16`=1, `{hi_q,lo_q}` is one 16-bit counter that rises by one per enabled tick.
- R6: With `mode16`=0, the count is `{hi_q, lo_q[4:0]}`. `lo_q[4:0]` carries into `hi_q` when it passes 31, and `lo_q[7:5]` keep their written value.
- R7: An enabled tick taken at the all-ones count of the active mode wraps the count to zero and sets `ovf`.
- R8: With `src_ext`=0 and `pre_undiv`=1 every clock is a tick. With `src_ext`=0 and `pre_undiv`=0 a free-running prescaler gives exactly one tick in every 12 consecutive clocks.
- R9: With `src_ext`=1, each high-to-low transition of `cnt_pin` gives exactly one tick, and rising edges give none. The count shows the increment after the third rising clock edge that follows the pin's fall.
- R10: A `lo_wr` or `hi_wr` strobe loads `wr_data` into its byte and cancels any increment or overflow in that cycle.
- R11: `ovf` stays set until `ovf_clr` is pulsed. If a clear and a new overflow fall in the same cycle, `ovf` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run control |
| gate_en | input | 1 | Makes counting depend on `gate_in` |
| gate_in | input | 1 | External gate level, active high |
| src_ext | input | 1 | 1 = count falling edges of `cnt_pin`, 0 = internal time base |
| pre_undiv | input | 1 | 1 = undivided clock, 0 = clock divided by 12 |
| mode16 | input | 1 | 1 = 16-bit mode, 0 = 13-bit mode |
| cnt_pin | input | 1 | External count pin, asynchronous |
| lo_wr | input | 1 | Low byte write strobe |
| hi_wr | input | 1 | High byte write strobe |
| wr_data | input | 8 | Write data for either byte |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| lo_q | output | 8 | Low count byte |
| hi_q | output | 8 | High count byte |
| ovf | output | 1 | Overflow flag |

## Verification
The bench goes after these corner cases:

- **13-bit carry.** It is loaded with set upper bits in the low byte. A design that carried out of bit 7 instead of bit 4 would leave the high byte stale. A design that counted the upper bits would change them.
- **Gating table.** All four gating combinations are walked. A design that ignored `gate_en`, or let `gate_in` through while `gate_en`=0, would count while it should hold, or hold while it should count.
- **Write and clear collisions.** A write is landed on an increment cycle, and a clear is landed on an overflow cycle. A design with the wrong priority would show the written value plus one, or would lose the flag.
- **External edge timing.** Edge counting is checked edge by edge. This catches a design that counts rising edges, counts a held level, or uses a different synchronizer depth.

// File: rtl/gate_timer.sv
module gate_timer #(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int LOW13_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              gate_en,
  input  logic              gate_in,
  input  logic              src_ext,
  input  logic              pre_undiv,
  input  logic              mode16,
  input  logic              cnt_pin,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf
);
  localparam int PW      = $clog2(PRESCALE);
  localparam int FULL_W  = 2 * BYTE_W;
  localparam int SHORT_W = BYTE_W + LOW13_W;

  logic [PW-1:0]          pre_cnt;
  logic [SYNC_STAGES-1:0] pin_sync;
  logic                   pin_prev;

  wire pre_tick = (pre_cnt == PW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (rst)           pre_cnt <= '0;
    else if (pre_tick) pre_cnt <= '0;
    else               pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_sync <= '0;
      pin_prev <= 1'b0;
    end else begin
      pin_sync <= {pin_sync[SYNC_STAGES-2:0], cnt_pin};
      pin_prev <= pin_sync[SYNC_STAGES-1];
    end
  end

  wire pin_fall = pin_prev & ~pin_sync[SYNC_STAGES-1];
  wire int_tick = pre_undiv | pre_tick;
  wire src_tick = src_ext ? pin_fall : int_tick;
  wire allowed  = run_en & (~gate_en | gate_in);
  wire inc      = allowed & src_tick & ~lo_wr & ~hi_wr;

  wire [FULL_W-1:0]  wide  = {hi_q, lo_q};
  wire [SHORT_W-1:0] short = {hi_q, lo_q[LOW13_W-1:0]};
  wire [FULL_W-1:0]  wide_nxt  = wide + 1'b1;
  wire [SHORT_W-1:0] short_nxt = short + 1'b1;
  wire at_top = mode16 ? (&wide) : (&short);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_wr) lo_q <= wr_data;
      if (hi_wr) hi_q <= wr_data;
      if (inc) begin
        if (mode16) begin
          {hi_q, lo_q} <= wide_nxt;
        end else begin
          hi_q               <= short_nxt[SHORT_W-1:LOW13_W];
          lo_q[LOW13_W-1:0]  <= short_nxt[LOW13_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               ovf <= 1'b0;
    else if (inc & at_top) ovf <= 1'b1;
    else if (ovf_clr)      ovf <= 1'b0;
  end
endmodule

// File: rtl/gate_timer_chk.sv
module gate_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic       run_en,
  input logic       gate_en,
  input logic       gate_in,
  input logic       mode16,
  input logic       lo_wr,
  input logic       hi_wr,
  input logic [7:0] wr_data,
  input logic       ovf_clr,
  input logic [7:0] lo_q,
  input logic [7:0] hi_q,
  input logic       ovf
);
  wire no_wr = !lo_wr && !hi_wr;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (lo_q == 8'h00 && hi_q == 8'h00 && !ovf)); // R1

  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (run_en && gate_en && !gate_in && no_wr) |=> ($stable(lo_q) && $stable(hi_q))); // R2

  AST_RUN_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run_en && no_wr) |=> ($stable(lo_q) && $stable(hi_q))); // R3

  AST_WIDE_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode16 && no_wr) |=> ({hi_q, lo_q} == $past({hi_q, lo_q}) ||
                           {hi_q, lo_q} == $past({hi_q, lo_q}) + 16'd1)); // R5

  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!mode16 && !lo_wr) |=> (lo_q[7:5] == $past(lo_q[7:5]))); // R6

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(mode16 ? ({hi_q, lo_q} == 16'hFFFF)
                                : ({hi_q, lo_q[4:0]} == 13'h1FFF))); // R7

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> (lo_q == $past(wr_data))); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf); // R11
endmodule

bind gate_timer gate_timer_chk u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .gate_en(gate_en), .gate_in(gate_in),
  .mode16(mode16), .lo_wr(lo_wr), .hi_wr(hi_wr), .wr_data(wr_data),
  .ovf_clr(ovf_clr), .lo_q(lo_q), .hi_q(hi_q), .ovf(ovf)
);

// File: tb/gate_timer_bench.sv
module gate_timer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 0, gate_en = 0, gate_in = 0, src_ext = 0, pre_undiv = 1, mode16 = 1;
  logic cnt_pin = 0, lo_wr = 0, hi_wr = 0, ovf_clr = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] lo_q, hi_q;
  logic ovf;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gate_timer u_gate_timer (
    .clk(clk), .rst(rst), .run_en(run_en), .gate_en(gate_en), .gate_in(gate_in),
    .src_ext(src_ext), .pre_undiv(pre_undiv), .mode16(mode16), .cnt_pin(cnt_pin),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .lo_q(lo_q), .hi_q(hi_q), .ovf(ovf)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [7:0] lo, logic [7:0] hi);
    @(negedge clk); lo_wr = 1; wr_data = lo;
    @(negedge clk); lo_wr = 0; hi_wr = 1; wr_data = hi;
    @(negedge clk); hi_wr = 0;
  endtask

  task automatic t_reset;
    chk("R1 lo", {8'h00, lo_q}, 16'h0000);
    chk("R1 hi", {8'h00, hi_q}, 16'h0000);
    chk("R1 ovf", {15'd0, ovf}, 16'h0000);
  endtask

  task automatic t_wide_run;
    run_en = 0; mode16 = 1; pre_undiv = 1; src_ext = 0;
    load(8'hF0, 8'h12);
    tick(3);
    chk("R3 held while stopped", {hi_q, lo_q}, 16'h12F0);
    run_en = 1;
    tick(5);
    chk("R4 R5 counts from loaded value", {hi_q, lo_q}, 16'h12F5);
    tick(12);
    chk("R5 carry into high byte", {hi_q, lo_q}, 16'h1301);
    run_en = 0;
  endtask

  task automatic t_gating;
    mode16 = 1; pre_undiv = 1; src_ext = 0;
    load(8'h00, 8'h00);
    run_en = 1; gate_en = 1; gate_in = 0;
    tick(4);
    chk("R2 gate low blocks", {hi_q, lo_q}, 16'h0000);
    gate_in = 1;
    tick(4);
    chk("R2 gate high counts", {hi_q, lo_q}, 16'h0004);
    gate_en = 0; gate_in = 0;
    tick(4);
    chk("R3 gate ignored when disabled", {hi_q, lo_q}, 16'h0008);
    run_en = 0; gate_en = 1; gate_in = 1;
    tick(4);
    chk("R3 run off overrides gate", {hi_q, lo_q}, 16'h0008);
    gate_en = 0; gate_in = 0;
  endtask

  task automatic t_short;
    run_en = 0; mode16 = 0; pre_undiv = 1; src_ext = 0;
    load(8'hFF, 8'h12);
    run_en = 1; tick(1); run_en = 0;
    chk("R6 carry from bit 4", {hi_q, lo_q}, 16'h13E0);
    load(8'hBE, 8'hFF);
    ovf_clr = 1; tick(1); ovf_clr = 0;
    run_en = 1; tick(1);
    chk("R6 low field to 31", {hi_q, lo_q}, 16'hFFBF);
    chk("R7 no flag before wrap", {15'd0, ovf}, 16'h0000);
    tick(1); run_en = 0;
    chk("R6 R7 13-bit wrap keeps upper bits", {hi_q, lo_q}, 16'h00A0);
    chk("R7 flag on 13-bit wrap", {15'd0, ovf}, 16'h0001);
    ovf_clr = 1; tick(1); ovf_clr = 0;
    chk("R11 clear", {15'd0, ovf}, 16'h0000);
  endtask

  task automatic t_prescale;
    run_en = 0; mode16 = 1; pre_undiv = 0; src_ext = 0;
    load(8'h00, 8'h00);
    run_en = 1; tick(36); run_en = 0;
    chk("R8 three ticks in 36 clocks", {hi_q, lo_q}, 16'h0003);
    pre_undiv = 1;
  endtask

  task automatic t_external;
    run_en = 0; mode16 = 1; src_ext = 1; cnt_pin = 0;
    load(8'h00, 8'h00);
    run_en = 1;
    cnt_pin = 1; tick(5);
    chk("R9 rising edge ignored", {hi_q, lo_q}, 16'h0000);
    cnt_pin = 0; tick(2);
    chk("R9 not yet after two edges", {hi_q, lo_q}, 16'h0000);
    tick(1);
    chk("R9 counted on third edge", {hi_q, lo_q}, 16'h0001);
    tick(5);
    chk("R9 low level counts once", {hi_q, lo_q}, 16'h0001);
    for (int i = 0; i < 4; i++) begin
      cnt_pin = 1; tick(3);
      cnt_pin = 0; tick(3);
    end
    tick(3);
    chk("R9 four more falls", {hi_q, lo_q}, 16'h0005);
    run_en = 0; src_ext = 0;
  endtask

  task automatic t_write_prio;
    run_en = 0; mode16 = 1; pre_undiv = 1;
    load(8'h10, 8'h05);
    run_en = 1;
    lo_wr = 1; wr_data = 8'h40;
    tick(1);
    lo_wr = 0;
    chk("R10 write beats increment", {hi_q, lo_q}, 16'h0540);
    tick(1);
    chk("R10 counting resumes", {hi_q, lo_q}, 16'h0541);
    run_en = 0;
  endtask

  task automatic t_ovf_prio;
    run_en = 0; mode16 = 1; pre_undiv = 1;
    load(8'hFF, 8'hFF);
    run_en = 1; ovf_clr = 1;
    tick(1);
    ovf_clr = 0;
    chk("R7 16-bit wrap value", {hi_q, lo_q}, 16'h0000);
    chk("R11 set wins over clear", {15'd0, ovf}, 16'h0001);
    tick(3);
    chk("R11 flag sticky", {15'd0, ovf}, 16'h0001);
    run_en = 0; ovf_clr = 1;
    tick(1);
    ovf_clr = 0;
    chk("R11 explicit clear", {15'd0, ovf}, 16'h0000);
  endtask

  task automatic t_reset_mid;
    run_en = 1; tick(3);
    rst = 1; tick(1); rst = 0; run_en = 0;
    chk("R1 reset mid-run", {15'd0, ovf, hi_q, lo_q} == 0 ? 16'h0 : 16'h1, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    t_reset();
    t_wide_run();
    t_gating();
    t_short();
    t_prescale();
    t_external();
    t_write_prio();
    t_ovf_prio();
    t_reset_mid();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule